// File: doc/BRIEF.md
# Scaled-Feedback Fixed-Point Accumulator

This block is a clocked, signed, two's-complement accumulator. On every cycle where the clock enable is high, it forms a new result from two terms. The first is the stored result, divided by a power of two. The second is the incoming sample, which is either added or subtracted. The result is registered, so it appears one clock after the sample. The output keeps the input's width and binary-point position, because the block never moves the radix point.

Elaboration-time parameters fix the configuration:
- the data width;
- the feedback shift, from 0 to 8, which gives a feedback factor of 1 down to 1/256;
- the operation, add or subtract;
- the overflow policy, wrap or saturate;
- the reset behaviour, which either clears the result or loads the sample present on the input.

The block suits leaky integrators, first-order smoothing filters and running sums in datapath pipelines.

Top module: `scaled_accum`

## Requirements
- R1: With the reload option off, a cycle with `rst` high makes `q` equal zero after that clock edge.
- R2: With the reload option on, a cycle with `rst` high makes `q` equal the value on `b` during that cycle.
- R3: `rst` takes precedence over `ce`: when both are high, the result is the reset value and not an accumulated one.
- R4: When `rst` is low and `ce` is low, `q` keeps its value. A change on `b` has no effect.
- R5: In add mode, an enabled cycle gives `q_next = (q >>> SHIFT) + b`.
- R6: In subtract mode, an enabled cycle gives `q_next = (q >>> SHIFT) - b`.
- R7: The scaling is an arithmetic right shift, which rounds toward negative infinity. For example, a stored -1 stays -1 after any shift.
- R8: A shift of 0 applies no scaling, and a shift of 8 divides the stored value by 256.
- R9: In saturate mode, a result above 2^(W-1)-1 becomes 2^(W-1)-1, and a result below -2^(W-1) becomes -2^(W-1).
- R10: In wrap mode, the result is taken modulo 2^W and read as two's complement.
- R11: The latency is exactly one clock: a sample presented in one cycle is reflected in `q` right after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the result or reloads it from `b` |
| ce | input | 1 | Clock enable for accumulation |
| b | input | DATA_W | Signed input sample |
| q | output | DATA_W | Registered signed result, in the same format as `b` |

## Verification
Reset and clock enable can both be high in the same cycle. Reset must win, and in reload configurations it must also capture that cycle's sample rather than an accumulated sum. The bench provokes this by accumulating to a non-zero value and then raising `rst` and `ce` together with a distinctive sample. It then judges the clearing instance and the reloading instance against their different expected results. A second collision arises when scaling and overflow handling act on the same operation. Driving full-scale samples of both signs shows whether saturation clamps to the correct rail after the shifted feedback has been added.

// File: rtl/scaled_accum_pkg.sv
package scaled_accum_pkg;

  typedef enum bit {
    ACC_ADD = 1'b0,
    ACC_SUB = 1'b1
  } acc_op_e;

  typedef enum bit {
    OVF_WRAP = 1'b0,
    OVF_SAT  = 1'b1
  } ovf_mode_e;

  localparam int MAX_FEEDBACK_SHIFT = 8;

endpackage

// File: rtl/sacc_scale.sv
module sacc_scale #(
  parameter int W     = 16,
  parameter int SHIFT = 2
) (
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);
  import scaled_accum_pkg::*;

  generate
    if (SHIFT == 0) begin : g_unity
      assign y = x;
    end else begin : g_shift
      assign y = x >>> SHIFT;
    end
  endgenerate

  always_comb begin
    assert (y[W-1] == x[W-1] || SHIFT >= W)
      else $error("p_sign_kept_r7: scaling changed the sign");
  end

  initial begin
    assert (SHIFT >= 0 && SHIFT <= MAX_FEEDBACK_SHIFT)
      else $error("p_shift_range_r8: feedback shift outside 0..8");
  end
endmodule

// File: rtl/sacc_combine.sv
module sacc_combine #(
  parameter int W = 16,
  parameter scaled_accum_pkg::acc_op_e OP = scaled_accum_pkg::ACC_ADD
) (
  input  logic signed [W-1:0] fb,
  input  logic signed [W-1:0] smp,
  output logic signed [W:0]   sum
);
  import scaled_accum_pkg::*;

  logic signed [W:0] fb_x, smp_x;
  assign fb_x  = {fb[W-1], fb};
  assign smp_x = {smp[W-1], smp};

  generate
    if (OP == ACC_SUB) begin : g_sub
      assign sum = fb_x - smp_x;
    end else begin : g_add
      assign sum = fb_x + smp_x;
    end
  endgenerate
endmodule

// File: rtl/sacc_limit.sv
module sacc_limit #(
  parameter int W = 16,
  parameter scaled_accum_pkg::ovf_mode_e MODE = scaled_accum_pkg::OVF_SAT
) (
  input  logic signed [W:0]   wide,
  output logic signed [W-1:0] res
);
  import scaled_accum_pkg::*;

  localparam logic [W-1:0] POS_RAIL = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_RAIL = {1'b1, {(W-1){1'b0}}};

  generate
    if (MODE == OVF_SAT) begin : g_sat
      logic over;
      assign over = wide[W] ^ wide[W-1];
      always_comb begin
        if (!over)       res = wide[W-1:0];
        else if (wide[W]) res = NEG_RAIL;
        else             res = POS_RAIL;
      end
    end else begin : g_wrap
      logic wrap_unused;
      assign wrap_unused = wide[W];
      assign res = wide[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/scaled_accum.sv
module scaled_accum #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 2,
  parameter scaled_accum_pkg::acc_op_e   OP     = scaled_accum_pkg::ACC_ADD,
  parameter scaled_accum_pkg::ovf_mode_e OVF    = scaled_accum_pkg::OVF_SAT,
  parameter bit                          RELOAD = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] q
);
  import scaled_accum_pkg::*;

  localparam logic [DATA_W-1:0] NEG_RAIL = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] acc_r;
  logic signed [DATA_W-1:0] fb_scaled;
  logic signed [DATA_W:0]   raw_sum;
  logic signed [DATA_W-1:0] next_val;

  sacc_scale #(.W(DATA_W), .SHIFT(SHIFT)) u_scale (
    .x (acc_r),
    .y (fb_scaled)
  );

  sacc_combine #(.W(DATA_W), .OP(OP)) u_comb (
    .fb  (fb_scaled),
    .smp (b),
    .sum (raw_sum)
  );

  sacc_limit #(.W(DATA_W), .MODE(OVF)) u_limit (
    .wide (raw_sum),
    .res  (next_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r <= RELOAD ? b : '0;
    end else if (ce) begin
      acc_r <= next_val;
    end
  end

  assign q = acc_r;

  // R1 R2 R3: reset outcome, whatever ce does
  p_reset_value_r3: assert property (@(posedge clk)
    rst |=> q == (RELOAD ? $past(b) : '0));

  // R4: hold when idle
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));

  // R5 R6 R11: from an empty accumulator the sample lands one clock later
  p_from_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (ce && q == '0 && (OVF == OVF_WRAP || b != NEG_RAIL))
    |=> q == ((OP == ACC_SUB) ? -$past(b) : $past(b)));

  // R9: like-signed growth never flips a non-negative result negative
  generate
    if (OVF == OVF_SAT) begin : g_sat_chk
      p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (ce && !q[DATA_W-1] && ((OP == ACC_SUB) ? b[DATA_W-1] : !b[DATA_W-1]))
        |=> !q[DATA_W-1]);
    end
  endgenerate
endmodule

// File: tb/tb_scaled_accum.sv
module tb_scaled_accum;
  import scaled_accum_pkg::*;

  localparam int W = 16;
  localparam int MAXI = 2**(W-1) - 1;
  localparam int MINI = -(2**(W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce  = 1'b0;
  logic signed [W-1:0] b = '0;
  logic signed [W-1:0] q0, q1, q2;
  logic signed [W-1:0] m0 = '0, m1 = '0, m2 = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  // add, shift 2, saturate, clear on reset
  scaled_accum #(.DATA_W(W), .SHIFT(2), .OP(ACC_ADD), .OVF(OVF_SAT), .RELOAD(1'b0)) dut (
    .clk(clk), .rst(rst), .ce(ce), .b(b), .q(q0));
  // subtract, shift 0, wrap, reload on reset
  scaled_accum #(.DATA_W(W), .SHIFT(0), .OP(ACC_SUB), .OVF(OVF_WRAP), .RELOAD(1'b1)) u_sub (
    .clk(clk), .rst(rst), .ce(ce), .b(b), .q(q1));
  // add, shift 8, wrap, clear on reset
  scaled_accum #(.DATA_W(W), .SHIFT(8), .OP(ACC_ADD), .OVF(OVF_WRAP), .RELOAD(1'b0)) u_s8 (
    .clk(clk), .rst(rst), .ce(ce), .b(b), .q(q2));

  function automatic logic signed [W-1:0] model(
    input logic signed [W-1:0] prev, input logic signed [W-1:0] smp,
    input bit r, input bit c, input int sh, input bit sub, input bit sat, input bit rel);
    logic signed [W-1:0] s;
    int t;
    if (r) return rel ? smp : '0;
    if (!c) return prev;
    s = prev >>> sh;
    t = sub ? (int'(s) - int'(smp)) : (int'(s) + int'(smp));
    if (sat && t > MAXI) return MAXI[W-1:0];
    if (sat && t < MINI) return MINI[W-1:0];
    return t[W-1:0];
  endfunction

  task automatic chk(input string tag, input logic signed [W-1:0] act, input int exp);
    checks++;
    if (act !== exp[W-1:0]) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare every instance to its model after the edge
  task automatic step(input bit r, input bit c, input logic signed [W-1:0] v, input string tag);
    @(negedge clk);
    rst = r; ce = c; b = v;
    @(posedge clk);
    #1;
    m0 = model(m0, v, r, c, 2, 1'b0, 1'b1, 1'b0);
    m1 = model(m1, v, r, c, 0, 1'b1, 1'b0, 1'b1);
    m2 = model(m2, v, r, c, 8, 1'b0, 1'b0, 1'b0);
    chk({tag, " dut"}, q0, m0);
    chk({tag, " u_sub"}, q1, m1);
    chk({tag, " u_s8"}, q2, m2);
  endtask

  task automatic t_reset();
    step(1, 0, 16'sd1234, "R1");
    chk("R1 clear", q0, 0);
    chk("R2 reload", q1, 1234);
    chk("R1 clear s8", q2, 0);
  endtask

  task automatic t_rst_over_ce();
    step(0, 1, 16'sd100, "R3");
    step(1, 1, 16'sd500, "R3");
    chk("R3 clear wins", q0, 0);
    chk("R3 reload wins", q1, 500);
  endtask

  task automatic t_hold();
    logic signed [W-1:0] h0, h1;
    step(0, 1, 16'sd40, "R4");
    h0 = q0; h1 = q1;
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 16'sd999 + 16'(i), "R4");
      chk("R4 hold dut", q0, h0);
      chk("R4 hold sub", q1, h1);
    end
  endtask

  task automatic t_add();
    step(1, 0, 16'sd0, "R5");
    step(0, 1, 16'sd400, "R11");
    chk("R11 one clock", q0, 400);
    step(0, 1, 16'sd8, "R5");
    chk("R5 add", q0, 108);
    step(0, 1, -16'sd20, "R5");
    chk("R5 add neg", q0, 7);
  endtask

  task automatic t_sub();
    step(1, 0, 16'sd50, "R6");
    step(0, 1, 16'sd20, "R6");
    chk("R6 sub", q1, 30);
    step(0, 1, -16'sd5, "R6");
    chk("R6 sub neg", q1, 35);
  endtask

  task automatic t_floor();
    step(1, 0, 16'sd0, "R7");
    step(0, 1, -16'sd1, "R7");
    step(0, 1, 16'sd0, "R7");
    chk("R7 floor s8", q2, -1);
    chk("R7 floor s2", q0, -1);
  endtask

  task automatic t_shift_ends();
    step(1, 0, 16'sd1000, "R8");
    step(0, 1, 16'sd512, "R8");
    step(0, 1, 16'sd0, "R8");
    chk("R8 shift 8", q2, 2);
    step(1, 0, 16'sd1000, "R8");
    step(0, 1, 16'sd0, "R8");
    chk("R8 shift 0", q1, 1000);
  endtask

  task automatic t_saturate();
    step(1, 0, 16'sd0, "R9");
    step(0, 1, 16'sd32767, "R9");
    step(0, 1, 16'sd32767, "R9");
    chk("R9 pos rail", q0, MAXI);
    step(0, 1, 16'sh8000, "R9");
    chk("R9 mid", q0, -24577);
    step(0, 1, 16'sh8000, "R9");
    chk("R9 neg rail", q0, MINI);
  endtask

  task automatic t_wrap();
    step(1, 0, 16'sd32767, "R10");
    step(0, 1, -16'sd1, "R10");
    chk("R10 wrap sub", q1, MINI);
    step(1, 0, 16'sd0, "R10");
    step(0, 1, 16'sd32767, "R10");
    step(0, 1, 16'sd32767, "R10");
    chk("R10 wrap add", q2, -32642);
  endtask

  task automatic t_sweep();
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0] == 4'd0, lf[5] | lf[6], lf ^ 16'h5A3C, "R11 sweep");
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL R11 watchdog actual=%0d expected=<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rst_over_ce();
    t_hold();
    t_add();
    t_sub();
    t_floor();
    t_shift_ends();
    t_saturate();
    t_wrap();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule